// File: doc/BRIEF.md
# Prescaled Backlight PWM Generator

This block makes one pulse-width-modulated waveform from a reference clock, for example to dim a display backlight. A host sets it up through a simple byte-wide register port. An 8-bit prescaler divides the reference clock into ticks. A 16-bit period counter advances on those ticks. A 16-bit duty value sets how many ticks of each period the output is active.

A control byte turns the generator on and can invert its output. The waveform does not go straight to a pin. It reaches one shared general-purpose pad through a 2-bit function selector. That selector picks between a tri-stated input, a plain driven output, and the PWM. The timing registers are copied into working copies only at a period boundary, so a host can retune the generator without cutting a period short.

Top module: `bl_pwm_gen`

## Requirements
- R1: After reset, every register reads 0 and the pad is not driven (`pad_oe` = 0).
- R2: Register addresses are as follows. Prescale is at 0xA0. Period scale is at 0xA1 (low byte) and 0xA2 (high byte). Duty is at 0xA3 (low byte) and 0xA4 (high byte). Control is at 0xA5, with bit 1 = enable, bit 0 = invert, and the other bits reading 0. Pad function is at 0xA6 as a full byte. Every register reads back what was last written.
- R3: One period lasts D × (SCALE + 1) reference cycles, where D is the prescale value.
- R4: Each period starts with the active phase. The active phase lasts D × min(DUTY, SCALE + 1) reference cycles, so a duty above the scale gives a constantly active output.
- R5: With invert = 1 the waveform is the complement, so the active level is low.
- R6: With enable = 0, the output sits at the inactive level from the cycle after the write, and the counters are held at zero. The cycle after enable is captured, the output is held at the inactive level. The first period begins on the cycle after that.
- R7: Prescale, scale, duty and invert values written while the generator runs take effect only from the next period boundary. The current period completes with its old values.
- R8: Pad 3 is controlled by bits [7:6] of the pad function byte. 00 or 11 leaves the pad undriven. 01 drives `gpio_dout`. 10 drives the PWM waveform.
- R9: A prescale value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| gpio_dout | input | 1 | Plain output value for the pad |
| pad_out | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output enable |

## Verification
A host write to a timing register can land in the middle of a running period. Separately, the period boundary reloads the working copies. The bench writes the duty low byte two cycles into a running period. It then checks that this period keeps the old active count and that the next one uses the new value. The bench also drops enable partway through a period, and checks the inactive level and a clean restart at the start of a period.

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
  parameter logic [7:0] BASE_ADDR = 8'hA0,
  parameter logic [7:0] PADF_ADDR = 8'hA6,
  parameter int         PIN_IDX   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       gpio_dout,
  output logic       pad_out,
  output logic       pad_oe
);
  localparam logic [7:0] A_PRE = BASE_ADDR;
  localparam logic [7:0] A_SCL = BASE_ADDR + 8'd1;
  localparam logic [7:0] A_SCH = BASE_ADDR + 8'd2;
  localparam logic [7:0] A_DTL = BASE_ADDR + 8'd3;
  localparam logic [7:0] A_DTH = BASE_ADDR + 8'd4;
  localparam logic [7:0] A_CTL = BASE_ADDR + 8'd5;
  localparam int         FSEL  = 2 * PIN_IDX;

  logic [7:0]  r_pre, r_padf;
  logic [15:0] r_scale, r_duty;
  logic        r_en, r_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_pre   <= '0;
      r_scale <= '0;
      r_duty  <= '0;
      r_en    <= 1'b0;
      r_inv   <= 1'b0;
      r_padf  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_PRE:     r_pre         <= reg_wdata;
        A_SCL:     r_scale[7:0]  <= reg_wdata;
        A_SCH:     r_scale[15:8] <= reg_wdata;
        A_DTL:     r_duty[7:0]   <= reg_wdata;
        A_DTH:     r_duty[15:8]  <= reg_wdata;
        A_CTL:     {r_en, r_inv} <= reg_wdata[1:0];
        PADF_ADDR: r_padf        <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      A_PRE:     reg_rdata = r_pre;
      A_SCL:     reg_rdata = r_scale[7:0];
      A_SCH:     reg_rdata = r_scale[15:8];
      A_DTL:     reg_rdata = r_duty[7:0];
      A_DTH:     reg_rdata = r_duty[15:8];
      A_CTL:     reg_rdata = {6'd0, r_en, r_inv};
      PADF_ADDR: reg_rdata = r_padf;
      default:   reg_rdata = '0;
    endcase
  end

  logic [7:0]  a_pd, pre_cnt;
  logic [15:0] a_scale, a_duty, per_cnt;
  logic        a_inv, run;

  wire [7:0] pd_eff = (r_pre == 8'd0) ? 8'd1 : r_pre;
  wire       tick   = (pre_cnt == a_pd - 8'd1);
  wire       wrap   = tick && (per_cnt == a_scale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      pre_cnt <= '0;
      per_cnt <= '0;
      a_pd    <= 8'd1;
      a_scale <= '0;
      a_duty  <= '0;
      a_inv   <= 1'b0;
    end else if (!r_en) begin
      run     <= 1'b0;
      pre_cnt <= '0;
      per_cnt <= '0;
    end else if (!run || wrap) begin
      run     <= 1'b1;
      pre_cnt <= '0;
      per_cnt <= '0;
      a_pd    <= pd_eff;
      a_scale <= r_scale;
      a_duty  <= r_duty;
      a_inv   <= r_inv;
    end else if (tick) begin
      pre_cnt <= '0;
      per_cnt <= per_cnt + 16'd1;
    end else begin
      pre_cnt <= pre_cnt + 8'd1;
    end
  end

  wire [16:0] hi_len = (a_duty > a_scale) ? ({1'b0, a_scale} + 17'd1) : {1'b0, a_duty};
  wire        active = ({1'b0, per_cnt} < hi_len);
  wire        pwm    = (run && r_en) ? (active ^ a_inv) : r_inv;

  always_comb begin
    case (r_padf[FSEL +: 2])
      2'b01:   begin pad_oe = 1'b1; pad_out = gpio_dout; end
      2'b10:   begin pad_oe = 1'b1; pad_out = pwm;       end
      default: begin pad_oe = 1'b0; pad_out = 1'b0;      end
    endcase
  end

  AST_PER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> per_cnt <= a_scale); // R3
  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_cnt < a_pd && a_pd != 8'd0)); // R9
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !r_en |=> (pre_cnt == 8'd0 && per_cnt == 16'd0 && !run)); // R6
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> ($stable(a_duty) && $stable(a_scale) && $stable(a_pd))); // R7
  AST_PAD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == PADF_ADDR && reg_wdata[FSEL +: 2] == 2'b00) |=> !pad_oe); // R8
endmodule

// File: tb/sim_bl_pwm_gen.sv
module sim_bl_pwm_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [7:0] reg_wdata = 8'h00;
  logic       gpio_dout = 1'b0;
  logic [7:0] reg_rdata;
  logic       pad_out, pad_oe;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bl_pwm_gen u0 (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_dout(gpio_dout),
    .pad_out(pad_out), .pad_oe(pad_oe));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp[7:0], req, reg_rdata, exp);
  endtask

  // counts active cycles over n samples, one per negedge; leaves at the next period start
  task automatic measure(input int n, input bit inv, output int hi, output bit first);
    hi = 0; first = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i == 0) first = pad_out ^ inv;
      if (pad_out ^ inv) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    int hi, hi2, d, per, exp_hi;
    bit first;
    repeat (3) @(negedge clk);
    chk(pad_oe == 1'b0, "R1 oe in reset", pad_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pad_oe == 1'b0, "R1 oe after reset", pad_oe, 0);
    for (int a = 8'hA0; a <= 8'hA6; a++) rd(a[7:0], 0, "R1 reset value");

    wr(8'hA0, 8'h5C); wr(8'hA1, 8'h34); wr(8'hA2, 8'h12);
    wr(8'hA3, 8'hCD); wr(8'hA4, 8'hAB); wr(8'hA5, 8'hFD); wr(8'hA6, 8'h3A);
    rd(8'hA0, 8'h5C, "R2 prescale");
    rd(8'hA1, 8'h34, "R2 scale lo"); rd(8'hA2, 8'h12, "R2 scale hi");
    rd(8'hA3, 8'hCD, "R2 duty lo");  rd(8'hA4, 8'hAB, "R2 duty hi");
    rd(8'hA5, 8'h01, "R2 control");  rd(8'hA6, 8'h3A, "R2 pad function");
    wr(8'hA5, 8'h00); wr(8'hA2, 8'h00); wr(8'hA4, 8'h00);

    // R8 pad function selector on pad 3
    wr(8'hA6, 8'h40); gpio_dout = 1'b1; #1;
    chk(pad_oe && pad_out, "R8 gpio 1", {pad_oe, pad_out}, 3);
    gpio_dout = 1'b0; #1;
    chk(pad_oe && !pad_out, "R8 gpio 0", {pad_oe, pad_out}, 2);
    wr(8'hA6, 8'hC0); #1;
    chk(!pad_oe, "R8 code 11 undriven", pad_oe, 0);
    wr(8'hA6, 8'h3F); #1;
    chk(!pad_oe, "R8 code 00 undriven", pad_oe, 0);
    wr(8'hA6, 8'h80); #1;
    chk(pad_oe, "R8 special drives", pad_oe, 1);

    // R3 R4 R5 R9 sweep
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        for (int b = 0; b < 6; b++)
          for (int v = 0; v < 2; v++) begin
            wr(8'hA5, {6'd0, 1'b0, v[0]});
            chk(pad_out == v[0], "R6 idle level", pad_out, v);
            wr(8'hA0, p[7:0]); wr(8'hA1, s[7:0]); wr(8'hA3, b[7:0]);
            wr(8'hA5, {6'd0, 1'b1, v[0]});
            chk(pad_out == v[0], "R6 inactive before start", pad_out, v);
            @(negedge clk);
            d = (p == 0) ? 1 : p;
            per = d * (s + 1);
            exp_hi = d * ((b > s) ? s + 1 : b);
            measure(per, v[0], hi, first);
            measure(per, v[0], hi2, first);
            chk(hi == exp_hi, p == 0 ? "R9 zero prescale high time" : (v ? "R5 inverted high time" : "R4 high time"), hi, exp_hi);
            chk(hi2 == exp_hi, "R3 period repeats", hi2, exp_hi);
            chk(first == (b > 0), "R4 period opens active", first, b > 0);
          end

    // R7 mid-period update: D=2, SCALE=3, duty 1 -> 3
    wr(8'hA5, 8'h00); wr(8'hA0, 8'd2); wr(8'hA1, 8'd3); wr(8'hA3, 8'd1);
    wr(8'hA5, 8'h02);
    @(negedge clk);
    hi = 0;
    for (int i = 0; i < 8; i++) begin
      if (pad_out) hi++;
      if (i == 2) begin reg_wr = 1'b1; reg_addr = 8'hA3; reg_wdata = 8'd3; end
      if (i == 3) reg_wr = 1'b0;
      @(negedge clk);
    end
    chk(hi == 2, "R7 current period keeps old duty", hi, 2);
    measure(8, 1'b0, hi, first);
    chk(hi == 6, "R7 next period uses new duty", hi, 6);

    // R6 disable mid-period then restart
    repeat (3) @(negedge clk);
    wr(8'hA5, 8'h01);
    hi = 0;
    for (int i = 0; i < 5; i++) begin
      if (!pad_out) hi++;
      @(negedge clk);
    end
    chk(hi == 0, "R6 disabled inverted rests high", hi, 0);
    wr(8'hA5, 8'h00);
    chk(pad_out == 1'b0, "R6 disabled rests low", pad_out, 0);
    wr(8'hA5, 8'h02);
    chk(pad_out == 1'b0, "R6 held on enable cycle", pad_out, 0);
    @(negedge clk);
    measure(8, 1'b0, hi, first);
    chk(hi == 6 && first, "R6 restart at period start", hi, 6);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule